// File: doc/BRIEF.md
# Banked Pin Interrupt Controller

This block turns one 32-bit group of general-purpose pins into a single interrupt line. Each of the four byte lanes of the bank is wired to one half of a 16-bit pin port that software picks through a routing register. The routed pins pass through a two-stage synchroniser and an optional per-pin inversion. Each pin then either raises a latched request on an edge or makes its request follow its level.

Software controls the mask, trigger type, polarity and both-edge behaviour through registers that come in set/clear pairs, so no read-modify-write is needed. It acknowledges a pin by writing one to its request bit. When a pin is in both-edge mode, that acknowledge also flips the pin's polarity, so the next opposite edge is caught by the same rising-edge detector. The interrupt output is the OR of the masked requests. A companion output gives the lowest pending pin index, so service runs from bit 0 upward.

Top module: `pint_bank`

## Requirements
- R1: Register offsets are mask set 0, mask clear 1, edge set 2, edge clear 3, invert set 4, invert clear 5, both-edge set 6, both-edge clear 7, request 8, routing 9 and pin view 10. For each of the four pairs, writing 1 to a bit at the set offset sets that bit, writing 1 at the clear offset clears it, and bits written 0 keep their value. Reading either offset of a pair returns the current value.
- R2: After reset every register reads zero, and `irq` is low.
- R3: The pin view (offset 10) shows the synchronised routed pins XOR the invert register, two clock edges after a pin change.
- R4: Byte lane L (bits 8L..8L+7) takes port P = routing[8L+7:8L]. Even lanes take bits 7:0 of port P and odd lanes take bits 15:8. Port P occupies `port_pins[16P+15:16P]`, and a value of P at or above the port count feeds zeros.
- R5: With its edge bit at 1, a pin sets its request bit when its inverted value goes from 0 to 1. The bit stays set after the pin returns, until 1 is written to it at offset 8.
- R6: With its edge bit at 0, a pin's request bit follows its inverted value, and writing 1 to it at offset 8 has no lasting effect.
- R7: An invert bit of 1 selects low level or falling edge, and 0 selects high level or rising edge.
- R8: `irq` is high exactly when (request AND mask) is nonzero, so a request on a masked-off pin keeps `irq` low.
- R9: Writing 1 at offset 8 to a bit whose both-edge bit is 1 flips that pin's invert bit in the same cycle as the acknowledge. Bits whose both-edge bit is 0 keep their invert value.
- R10: Writing 1 to a mask-set bit also clears that pin's stale edge request.
- R11: If a request clear and a new edge on the same bit fall in the same cycle, the request stays set.
- R12: While `irq` is high, `pend_idx` gives the lowest bit index set in (request AND mask).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| port_pins | input | 64 | Four 16-bit pin ports, port P in bits 16P+15:16P |
| irq | output | 1 | Bank interrupt |
| pend_idx | output | 5 | Lowest pending unmasked pin |

## Verification
The assertions assume that reset leaves the block with known inputs and that the bus carries at most one register write per cycle. Because of that, a mode register can never be rewritten in the same cycle as an acknowledge or an unmask. The stimulus changes pins and bus signals only on the falling clock edge and holds each pin level for at least four cycles. Only the directed test for the clear-versus-edge collision places a pin edge deliberately in the cycle of a clear. The random phase draws routing values up to two past the port count, so that unassigned lanes are covered.

// File: rtl/pint_pkg.sv
package pint_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_MSK_SET = 4'd0;
  localparam logic [ADDR_W-1:0] A_MSK_CLR = 4'd1;
  localparam logic [ADDR_W-1:0] A_EDG_SET = 4'd2;
  localparam logic [ADDR_W-1:0] A_EDG_CLR = 4'd3;
  localparam logic [ADDR_W-1:0] A_INV_SET = 4'd4;
  localparam logic [ADDR_W-1:0] A_INV_CLR = 4'd5;
  localparam logic [ADDR_W-1:0] A_BTH_SET = 4'd6;
  localparam logic [ADDR_W-1:0] A_BTH_CLR = 4'd7;
  localparam logic [ADDR_W-1:0] A_REQ     = 4'd8;
  localparam logic [ADDR_W-1:0] A_ROUTE   = 4'd9;
  localparam logic [ADDR_W-1:0] A_PINS    = 4'd10;
endpackage

// File: rtl/pint_sync.sv
module pint_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pint_route.sv
module pint_route #(
  parameter int LANES     = 4,
  parameter int LANE_W    = 8,
  parameter int NUM_PORTS = 4
) (
  input  logic [NUM_PORTS*2*LANE_W-1:0] ports,
  input  logic [LANES*8-1:0]            route,
  output logic [LANES*LANE_W-1:0]       lanes
);
  localparam int PORT_W = 2 * LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0]        sel;
    logic [LANE_W-1:0] val;
    assign sel = route[l*8 +: 8];
    always_comb begin
      val = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (sel == 8'(p)) val = ports[p*PORT_W + (l % 2)*LANE_W +: LANE_W];
      end
    end
    assign lanes[l*LANE_W +: LANE_W] = val;
  end
endmodule

// File: rtl/pint_regs.sv
module pint_regs
  import pint_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int LANES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  mask_q,
  output logic [WIDTH-1:0]  edge_q,
  output logic [WIDTH-1:0]  inv_q,
  output logic [WIDTH-1:0]  both_q,
  output logic [LANES*8-1:0] route_q
);
  logic [WIDTH-1:0]   mask_n, edge_n, inv_n, both_n;
  logic [LANES*8-1:0] route_n;

  always_comb begin
    mask_n  = mask_q;
    edge_n  = edge_q;
    inv_n   = inv_q;
    both_n  = both_q;
    route_n = route_q;
    case (bus_addr)
      A_MSK_SET: mask_n = mask_q | bus_wdata;
      A_MSK_CLR: mask_n = mask_q & ~bus_wdata;
      A_EDG_SET: edge_n = edge_q | bus_wdata;
      A_EDG_CLR: edge_n = edge_q & ~bus_wdata;
      A_INV_SET: inv_n  = inv_q | bus_wdata;
      A_INV_CLR: inv_n  = inv_q & ~bus_wdata;
      A_BTH_SET: both_n = both_q | bus_wdata;
      A_BTH_CLR: both_n = both_q & ~bus_wdata;
      A_REQ:     inv_n  = inv_q ^ (bus_wdata & both_q);
      A_ROUTE:   route_n = bus_wdata[LANES*8-1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      edge_q  <= '0;
      inv_q   <= '0;
      both_q  <= '0;
      route_q <= '0;
    end else if (bus_we) begin
      mask_q  <= mask_n;
      edge_q  <= edge_n;
      inv_q   <= inv_n;
      both_q  <= both_n;
      route_q <= route_n;
    end
  end

  // R9
  both_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_REQ) |=> (inv_q == ($past(inv_q) ^ $past(bus_wdata & both_q))));

  // R1
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_MSK_SET) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));
endmodule

// File: rtl/pint_detect.sv
module pint_detect #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_sync,
  input  logic [WIDTH-1:0] inv_q,
  input  logic [WIDTH-1:0] edge_mode,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] inv_val,
  output logic [WIDTH-1:0] edge_det,
  output logic [WIDTH-1:0] req_q
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] req_n;

  assign inv_val  = pins_sync ^ inv_q;
  assign edge_det = inv_val & ~prev_q;

  always_comb begin
    req_n = (edge_mode & ((req_q & ~clr_vec) | edge_det))
          | (~edge_mode & inv_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      req_q  <= '0;
    end else begin
      prev_q <= inv_val;
      req_q  <= req_n;
    end
  end

  // R11
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(edge_det & edge_mode & clr_vec)) |=>
      ((req_q & $past(edge_det & edge_mode & clr_vec)) == $past(edge_det & edge_mode & clr_vec)));
endmodule

// File: rtl/pint_bank.sv
module pint_bank
  import pint_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int LANE_W    = 8,
  parameter int NUM_PORTS = 4,
  parameter int SYNC_STG  = 2,
  localparam int WIDTH    = LANES * LANE_W,
  localparam int IDX_W    = $clog2(WIDTH),
  localparam int PINS_W   = NUM_PORTS * 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [PINS_W-1:0] port_pins,
  output logic              irq,
  output logic [IDX_W-1:0]  pend_idx
);
  logic [WIDTH-1:0]   mask_q, edge_q, inv_q, both_q;
  logic [LANES*8-1:0] route_q;
  logic [WIDTH-1:0]   lane_pins, pins_sync, inv_val, edge_det, req_q;
  logic [WIDTH-1:0]   clr_vec, pend_vec;

  pint_regs #(.WIDTH(WIDTH), .LANES(LANES)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mask_q(mask_q), .edge_q(edge_q),
    .inv_q(inv_q), .both_q(both_q), .route_q(route_q)
  );

  pint_route #(.LANES(LANES), .LANE_W(LANE_W), .NUM_PORTS(NUM_PORTS)) u_route (
    .ports(port_pins), .route(route_q), .lanes(lane_pins)
  );

  pint_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(lane_pins), .q(pins_sync)
  );

  always_comb begin
    clr_vec = '0;
    if (bus_we && (bus_addr == A_REQ || bus_addr == A_MSK_SET)) clr_vec = bus_wdata;
  end

  pint_detect #(.WIDTH(WIDTH)) u_det (
    .clk(clk), .rst_n(rst_n), .pins_sync(pins_sync), .inv_q(inv_q),
    .edge_mode(edge_q), .clr_vec(clr_vec), .inv_val(inv_val),
    .edge_det(edge_det), .req_q(req_q)
  );

  assign pend_vec = req_q & mask_q;
  assign irq      = |pend_vec;

  always_comb begin
    pend_idx = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (pend_vec[i]) pend_idx = IDX_W'(i);
    end
  end

  always_comb begin
    case (bus_addr)
      A_MSK_SET, A_MSK_CLR: bus_rdata = mask_q;
      A_EDG_SET, A_EDG_CLR: bus_rdata = edge_q;
      A_INV_SET, A_INV_CLR: bus_rdata = inv_q;
      A_BTH_SET, A_BTH_CLR: bus_rdata = both_q;
      A_REQ:                bus_rdata = req_q;
      A_ROUTE:              bus_rdata = WIDTH'(route_q);
      A_PINS:               bus_rdata = inv_val;
      default:              bus_rdata = '0;
    endcase
  end

  // R10
  unmask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_MSK_SET) |=> ((req_q & edge_q & $past(bus_wdata & ~edge_det)) == 0));

  // R12
  pend_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (req_q[pend_idx] && mask_q[pend_idx]));

  // R12
  pend_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((req_q & mask_q & ((WIDTH'(1) << pend_idx) - WIDTH'(1))) == 0));
endmodule

// File: tb/pint_bank_tb.sv
`timescale 1ns/1ps
module pint_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] port_pins = '0;
  logic        irq;
  logic [4:0]  pend_idx;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pint_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_pins(port_pins),
    .irq(irq), .pend_idx(pend_idx)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #0.5;
    v = bus_rdata;
  endtask

  function automatic logic [31:0] route_fn(logic [63:0] p, logic [31:0] r);
    logic [31:0] res = '0;
    for (int l = 0; l < 4; l++) begin
      int sel = int'(r[l*8 +: 8]);
      if (sel < 4) res[l*8 +: 8] = p[sel*16 + (l % 2)*8 +: 8];
    end
    return res;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a, b, c, exp_v, r, p_inv;
    void'($urandom(32'h5eed_1234));
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R2: reset state
    for (int k = 0; k <= 10; k++) begin
      rd(4'(k), v);
      chk("R2", v, 32'h0);
    end
    chk("R2 irq", {31'b0, irq}, 32'h0);

    // R1: set/clear pairs
    for (int k = 0; k < 4; k++) begin
      a = $urandom; b = $urandom; c = $urandom;
      wr(4'(2*k), a);
      wr(4'(2*k), b);
      wr(4'(2*k+1), c);
      exp_v = (a | b) & ~c;
      rd(4'(2*k), v);   chk("R1 set view", v, exp_v);
      rd(4'(2*k+1), v); chk("R1 clr view", v, exp_v);
      wr(4'(2*k+1), 32'hFFFF_FFFF);
      rd(4'(2*k), v);   chk("R1 cleared", v, 32'h0);
    end

    // R3, R4, R6: random routing, pins, polarity in level mode
    for (int it = 0; it < 24; it++) begin
      r = {8'($urandom % 6), 8'($urandom % 6), 8'($urandom % 6), 8'($urandom % 6)};
      p_inv = $urandom;
      wr(4'd9, r);
      wr(4'd4, p_inv);
      wr(4'd5, ~p_inv);
      @(negedge clk);
      port_pins = {$urandom, $urandom};
      tick(4);
      exp_v = route_fn(port_pins, r) ^ p_inv;
      rd(4'd10, v); chk("R3 R4 pin view", v, exp_v);
      rd(4'd8, v);  chk("R6 level follows", v, exp_v);
      wr(4'd8, 32'hFFFF_FFFF);
      tick(1);
      rd(4'd8, v);  chk("R6 clear ignored", v, exp_v);
    end

    // directed setup: lane L from port L
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd9, 32'h0302_0100);
    @(negedge clk); port_pins = '0;
    wr(4'd2, 32'hFFFF_FFFF);
    tick(4);
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, v); chk("R5 start clear", v, 32'h0);

    // R5: rising edge latches, survives pin drop
    @(negedge clk); port_pins[3] = 1'b1;
    tick(4);
    rd(4'd8, v); chk("R5 edge latched", v, 32'h8);
    @(negedge clk); port_pins[3] = 1'b0;
    tick(4);
    rd(4'd8, v); chk("R5 held", v, 32'h8);
    wr(4'd8, 32'h8);
    rd(4'd8, v); chk("R5 w1c", v, 32'h0);

    // R7: falling edge with invert set
    @(negedge clk); port_pins[3] = 1'b1;
    tick(4);
    wr(4'd4, 32'h8);
    tick(4);
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, v); chk("R7 no edge on high", v, 32'h0);
    @(negedge clk); port_pins[3] = 1'b0;
    tick(4);
    rd(4'd8, v);  chk("R7 falling caught", v, 32'h8);
    rd(4'd10, v); chk("R7 low reads one", v & 32'h8, 32'h8);
    wr(4'd5, 32'h8);
    tick(4);
    wr(4'd8, 32'hFFFF_FFFF);

    // R8, R12: irq and lowest index
    wr(4'd0, 32'h0000_0408);
    chk("R8 idle", {31'b0, irq}, 32'h0);
    @(negedge clk); port_pins[3] = 1'b1; port_pins[26] = 1'b1;
    tick(4);
    chk("R8 irq high", {31'b0, irq}, 32'h1);
    chk("R12 lowest", {27'b0, pend_idx}, 32'd3);
    wr(4'd8, 32'h8);
    #0.5;
    chk("R12 next", {27'b0, pend_idx}, 32'd10);
    chk("R8 still high", {31'b0, irq}, 32'h1);
    wr(4'd8, 32'h400);
    #0.5;
    chk("R8 drained", {31'b0, irq}, 32'h0);
    @(negedge clk); port_pins[5] = 1'b1;
    tick(4);
    rd(4'd8, v); chk("R8 masked req present", v, 32'h20);
    chk("R8 masked irq low", {31'b0, irq}, 32'h0);

    // R10: unmask clears stale request
    wr(4'd0, 32'h20);
    rd(4'd8, v); chk("R10 stale cleared", v, 32'h0);
    rd(4'd0, v); chk("R10 mask set", v & 32'h20, 32'h20);

    // R9: both-edge by invert flip
    wr(4'd6, 32'h20);
    wr(4'd8, 32'h20);
    rd(4'd4, v); chk("R9 flip on", v, 32'h20);
    @(negedge clk); port_pins[5] = 1'b0;
    tick(4);
    rd(4'd8, v); chk("R9 falling caught", v, 32'h20);
    wr(4'd8, 32'h20);
    rd(4'd4, v); chk("R9 flip off", v, 32'h0);
    @(negedge clk); port_pins[5] = 1'b1;
    tick(4);
    rd(4'd8, v); chk("R9 rising caught", v, 32'h20);
    wr(4'd8, 32'h28);
    rd(4'd4, v); chk("R9 only both bits flip", v, 32'h20);

    // R11: clear and new edge in the same cycle
    @(negedge clk); port_pins[3] = 1'b0;
    tick(4);
    @(negedge clk); port_pins[3] = 1'b1;
    tick(4);
    rd(4'd8, v); chk("R11 setup", v & 32'h8, 32'h8);
    @(negedge clk); port_pins[3] = 1'b0;
    tick(4);
    @(negedge clk); port_pins[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    wr(4'd8, 32'h8);
    rd(4'd8, v); chk("R11 edge wins", v & 32'h8, 32'h8);
    wr(4'd8, 32'h8);
    rd(4'd8, v); chk("R11 later clear", v & 32'h8, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule